// File: doc/BRIEF.md
# UART Line Status Tracker

This block keeps the eight line status bits of a UART whose receive and transmit paths may run with or without FIFOs. It watches the receiver's per-byte results, the transmitter's empty levels and the CPU's register accesses. It holds the received bytes in a small queue. Each entry carries three error tags next to its data byte: bad parity, missing stop bit and break. A tag turns into a visible status bit only when its byte becomes the oldest one in the queue. Three interrupt requests are formed from the status bits, and each one is gated by its own enable.

Receive data leaves the block on a valid/ready pair. `rd_valid` is status bit 0. The CPU's buffer read is `rd_ready`, and a byte is taken on every cycle in which both are high. The receiver side cannot be held back. `rx_valid` is a one-cycle strobe with no ready signal, and a byte that finds no room is lost and reported as an overrun. `fifo_en` selects FIFO mode (1) or single-buffer mode (0). Changing it empties the queue. Serial shifting, baud timing and resynchronisation after a framing error belong to the receiver and transmitter, not to this block.

Top module: `uart_lsr_tracker`

## Requirements
- R1: `lsr[0]` and `rd_valid` are 1 exactly while at least one byte is stored, and `rd_data` shows the oldest stored byte. A CPU read (`rd_ready`) removes that byte. A `fifo_clr` pulse empties the queue in FIFO mode and has no effect when `fifo_en` is 0.
- R2: The queue holds up to `DEPTH` bytes (default 16) in FIFO mode and 1 byte otherwise. A byte that arrives while the queue is full, with no read in the same cycle, is dropped and sets `lsr[1]` (overrun). With a read in the same cycle it is accepted.
- R3: `lsr[2]` (parity), `lsr[3]` (framing) and `lsr[4]` (break) are set by the tags of a byte at the moment that byte becomes the oldest in the queue, never earlier. Bytes leave in arrival order.
- R4: A byte received with the break tag is stored as 0x00, whatever its data value.
- R5: A pulse on `lsr_rd` clears `lsr[4:1]` after the clock edge, except for any of these bits that a new event sets in the same cycle, which stays 1.
- R6: In FIFO mode `lsr[7]` is 1 while any stored byte carries at least one tag. In single-buffer mode it is 0.
- R7: `lsr[5]` is 1 after reset. It clears on `thr_wr`, and it sets when `tx_hold_empty` rises from 0 to 1. A write in the same cycle as a rise leaves it 0.
- R8: `lsr[6]` is 1 only while `lsr[5]` is 1 and `tx_shift_empty` is 1.
- R9: `irq_rda = ien_rda & lsr[0]`, `irq_ls = ien_ls & (lsr[1] | lsr[2] | lsr[3] | lsr[4])` and `irq_thre = ien_thre & lsr[5]`.
- R10: Any change of `fifo_en` empties the queue at the next clock edge. The byte offered in that cycle is dropped and does not cause an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 = FIFO mode, 0 = single-buffer mode |
| rx_valid | input | 1 | Receiver finished a byte (one-cycle strobe) |
| rx_data | input | 8 | Received byte |
| rx_par_err | input | 1 | Byte failed the parity check |
| rx_frm_err | input | 1 | Byte had no valid stop bit |
| rx_brk | input | 1 | Break detected; byte stored as zero |
| rd_ready | input | 1 | CPU reads the receive buffer |
| rd_valid | output | 1 | A received byte is available |
| rd_data | output | 8 | Oldest received byte |
| lsr_rd | input | 1 | CPU reads the line status register |
| thr_wr | input | 1 | CPU writes the transmit holding register or FIFO |
| fifo_clr | input | 1 | CPU clears the receive FIFO |
| tx_hold_empty | input | 1 | Holding register or TX FIFO is empty (level) |
| tx_shift_empty | input | 1 | Transmit shift register is empty (level) |
| ien_rda | input | 1 | Enable for the receive-data interrupt |
| ien_ls | input | 1 | Enable for the line-status interrupt |
| ien_thre | input | 1 | Enable for the transmit-empty interrupt |
| lsr | output | 8 | Line status bits |
| irq_rda | output | 1 | Receive data available interrupt |
| irq_ls | output | 1 | Line status error interrupt |
| irq_thre | output | 1 | Transmit holding empty interrupt |

## Verification
The bench builds the tracker with `DEPTH = 4`. At that depth, filling the FIFO, an overrun on a full queue, pointer wrap-around and the tagged-entry count reaching and leaving zero all happen within a few cycles. It also makes each tag combination reach the head of the queue many times over in a short run. A long pseudo-random sweep toggles the mode, clear, read, write and enable inputs against an arithmetic model, and directed cases pin down break data, a status read that collides with an error event, and flushes caused by a mode change.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic par;
    logic frm;
    logic brk;
  } rx_tags_t;

  typedef struct packed {
    rx_tags_t          tags;
    logic [DATA_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/lsr_rx_queue.sv
module lsr_rx_queue
  import lsr_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              flush,
  input  logic              in_valid,
  input  rx_entry_t         in_entry,
  input  logic              pop_req,
  output logic [DATA_W-1:0] out_data,
  output logic              nonempty,
  output logic              overrun_evt,
  output logic              head_load,
  output rx_tags_t          head_tags,
  output logic              tag_any
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  rx_entry_t         mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr, nx_ptr;
  logic [CW-1:0]     count, count_nx, cap, tag_cnt;
  logic              full, push, pop, in_tagged, head_tagged;

  always_comb begin
    cap         = fifo_en ? CW'(DEPTH) : CW'(1);
    full        = count >= cap;
    pop         = pop_req && (count != '0) && !flush;
    push        = in_valid && !flush && (!full || pop);
    overrun_evt = in_valid && !flush && full && !pop;
    count_nx    = flush ? '0 : count + CW'(push) - CW'(pop);
    nx_ptr      = rd_ptr + AW'(1);
    head_load   = !flush && (count_nx != '0) && (pop || count == '0);
    head_tags   = (count == '0 || (pop && count == CW'(1))) ? in_entry.tags
                                                              : mem[nx_ptr].tags;
    in_tagged   = |in_entry.tags;
    head_tagged = |mem[rd_ptr].tags;
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      tag_cnt <= '0;
    end else if (flush) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      tag_cnt <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + AW'(1);
      if (pop)  rd_ptr <= nx_ptr;
      count   <= count_nx;
      tag_cnt <= tag_cnt + CW'(push && in_tagged) - CW'(pop && head_tagged);
    end
  end

  assign out_data = mem[rd_ptr].data;
  assign nonempty = count != '0;
  assign tag_any  = tag_cnt != '0;

  initial begin
    assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
      else $error("DEPTH must be a power of two, at least 2");
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R2
  AST_OVERRUN_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_evt |=> count == $past(count)); // R2
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count == '0); // R10
  AST_TAGS_WITHIN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    tag_cnt <= count); // R6
endmodule

// File: rtl/lsr_err_flags.sv
module lsr_err_flags #(
  parameter int NFLAG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_vec,
  input  logic             clr,
  output logic [NFLAG-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flags <= '0;
    else if (clr) flags <= set_vec;
    else          flags <= flags | set_vec;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec))); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && set_vec == '0) |=> flags == '0); // R5
endmodule

// File: rtl/lsr_tx_status.sv
module lsr_tx_status (
  input  logic clk,
  input  logic rst_n,
  input  logic thr_wr,
  input  logic tx_hold_empty,
  output logic thre
);
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b1;
      thre   <= 1'b1;
    end else begin
      hold_q <= tx_hold_empty;
      if (thr_wr)                      thre <= 1'b0;
      else if (tx_hold_empty && !hold_q) thre <= 1'b1;
    end
  end

  AST_WRITE_CLEARS_THRE: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !thre); // R7
  AST_THRE_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(thre) |-> $past(tx_hold_empty)); // R7
endmodule

// File: rtl/uart_lsr_tracker.sv
module uart_lsr_tracker
  import lsr_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_par_err,
  input  logic              rx_frm_err,
  input  logic              rx_brk,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              lsr_rd,
  input  logic              thr_wr,
  input  logic              fifo_clr,
  input  logic              tx_hold_empty,
  input  logic              tx_shift_empty,
  input  logic              ien_rda,
  input  logic              ien_ls,
  input  logic              ien_thre,
  output logic [7:0]        lsr,
  output logic              irq_rda,
  output logic              irq_ls,
  output logic              irq_thre
);
  logic      mode_q, flush;
  rx_entry_t in_entry;
  logic      nonempty, overrun_evt, head_load, tag_any, thre;
  rx_tags_t  head_tags;
  logic [3:0] err_set, err_flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= fifo_en;
  end

  always_comb begin
    flush              = (fifo_clr && fifo_en) || (fifo_en != mode_q);
    in_entry.data      = rx_brk ? '0 : rx_data;
    in_entry.tags.par  = rx_par_err;
    in_entry.tags.frm  = rx_frm_err;
    in_entry.tags.brk  = rx_brk;
    err_set[0]         = overrun_evt;
    err_set[1]         = head_load && head_tags.par;
    err_set[2]         = head_load && head_tags.frm;
    err_set[3]         = head_load && head_tags.brk;
  end

  lsr_rx_queue #(.DEPTH(DEPTH)) u_queue (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_en     (fifo_en),
    .flush       (flush),
    .in_valid    (rx_valid),
    .in_entry    (in_entry),
    .pop_req     (rd_ready),
    .out_data    (rd_data),
    .nonempty    (nonempty),
    .overrun_evt (overrun_evt),
    .head_load   (head_load),
    .head_tags   (head_tags),
    .tag_any     (tag_any)
  );

  lsr_err_flags #(.NFLAG(4)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (err_set),
    .clr     (lsr_rd),
    .flags   (err_flags)
  );

  lsr_tx_status u_tx (
    .clk           (clk),
    .rst_n         (rst_n),
    .thr_wr        (thr_wr),
    .tx_hold_empty (tx_hold_empty),
    .thre          (thre)
  );

  always_comb begin
    lsr[0]   = nonempty;
    lsr[4:1] = err_flags;
    lsr[5]   = thre;
    lsr[6]   = thre && tx_shift_empty;
    lsr[7]   = fifo_en && tag_any;
    rd_valid = nonempty;
    irq_rda  = ien_rda && lsr[0];
    irq_ls   = ien_ls && (|lsr[4:1]);
    irq_thre = ien_thre && lsr[5];
  end

  AST_BREAK_STORES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_brk && !nonempty && !flush) |=> rd_data == '0); // R4
  AST_NONFIFO_NO_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> !lsr[7]); // R6
endmodule

// File: tb/uart_lsr_tracker_test.sv
module uart_lsr_tracker_test;
  localparam int D = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 0, rx_valid = 0, rx_par_err = 0, rx_frm_err = 0, rx_brk = 0;
  logic [7:0] rx_data = 0;
  logic rd_ready = 0, lsr_rd = 0, thr_wr = 0, fifo_clr = 0;
  logic tx_hold_empty = 1, tx_shift_empty = 1;
  logic ien_rda = 0, ien_ls = 0, ien_thre = 0;
  logic rd_valid, irq_rda, irq_ls, irq_thre;
  logic [7:0] rd_data, lsr;

  always #10 clk = ~clk;

  uart_lsr_tracker #(.DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err),
    .rx_brk(rx_brk), .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .lsr_rd(lsr_rd), .thr_wr(thr_wr), .fifo_clr(fifo_clr),
    .tx_hold_empty(tx_hold_empty), .tx_shift_empty(tx_shift_empty),
    .ien_rda(ien_rda), .ien_ls(ien_ls), .ien_thre(ien_thre), .lsr(lsr),
    .irq_rda(irq_rda), .irq_ls(irq_ls), .irq_thre(irq_thre)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // model state
  logic [7:0] qd [D];
  logic       qp [D], qf [D], qb [D];
  int         m_cnt = 0;
  logic [3:0] m_err = 0;
  logic       m_thre = 1, m_hold = 1, m_mode = 0;
  logic [31:0] rng = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input string ctx,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] act=%0d exp=%0d", req, ctx, act, exp);
    end
  endtask

  function automatic int tagged_cnt();
    int n = 0;
    for (int i = 0; i < m_cnt; i++) if (qp[i] || qf[i] || qb[i]) n++;
    return n;
  endfunction

  task automatic model_step();
    int  cap;
    bit  flush, pop, push, ovr, hl;
    logic [3:0] setv;
    int  old;
    cap   = fifo_en ? D : 1;
    flush = (fifo_clr && fifo_en) || (fifo_en != m_mode);
    m_mode = fifo_en;
    setv = 0;
    if (flush) begin
      m_cnt = 0;
    end else begin
      old  = m_cnt;
      pop  = rd_ready && m_cnt > 0;
      push = rx_valid && (m_cnt < cap || pop);
      ovr  = rx_valid && !push;
      if (pop) begin
        for (int i = 0; i < D - 1; i++) begin
          qd[i] = qd[i+1]; qp[i] = qp[i+1]; qf[i] = qf[i+1]; qb[i] = qb[i+1];
        end
        m_cnt--;
      end
      if (push) begin
        qd[m_cnt] = rx_brk ? 8'h00 : rx_data;
        qp[m_cnt] = rx_par_err; qf[m_cnt] = rx_frm_err; qb[m_cnt] = rx_brk;
        m_cnt++;
      end
      hl = m_cnt > 0 && (pop || old == 0);
      setv[0] = ovr;
      if (hl) begin
        setv[1] = qp[0]; setv[2] = qf[0]; setv[3] = qb[0];
      end
    end
    m_err = lsr_rd ? setv : (m_err | setv);
    if (thr_wr) m_thre = 0;
    else if (tx_hold_empty && !m_hold) m_thre = 1;
    m_hold = tx_hold_empty;
  endtask

  task automatic compare(input string ctx);
    logic [7:0] e;
    e[0] = m_cnt > 0;
    e[4:1] = m_err;
    e[5] = m_thre;
    e[6] = m_thre && tx_shift_empty;
    e[7] = fifo_en && tagged_cnt() > 0;
    chk(lsr[0] == e[0] && rd_valid == e[0], "R1", ctx, lsr[0], e[0]);
    chk(lsr[1] == e[1], "R2", ctx, lsr[1], e[1]);
    chk(lsr[4:2] == e[4:2], "R3", ctx, lsr[4:2], e[4:2]);
    chk(lsr[5] == e[5], "R7", ctx, lsr[5], e[5]);
    chk(lsr[6] == e[6], "R8", ctx, lsr[6], e[6]);
    chk(lsr[7] == e[7], "R6", ctx, lsr[7], e[7]);
    if (m_cnt > 0) chk(rd_data == qd[0], "R1", ctx, rd_data, qd[0]);
    chk({irq_rda, irq_ls, irq_thre} ==
        {ien_rda && e[0], ien_ls && (|e[4:1]), ien_thre && e[5]},
        "R9", ctx, {irq_rda, irq_ls, irq_thre},
        {ien_rda && e[0], ien_ls && (|e[4:1]), ien_thre && e[5]});
  endtask

  task automatic tick(input string ctx);
    model_step();
    @(posedge clk); #1;
    compare(ctx);
    @(negedge clk);
  endtask

  task automatic idle();
    rx_valid = 0; rd_ready = 0; lsr_rd = 0; thr_wr = 0; fifo_clr = 0;
    rx_par_err = 0; rx_frm_err = 0; rx_brk = 0;
  endtask

  task automatic send(input logic [7:0] d, input logic [2:0] t, input string ctx);
    rx_valid = 1; rx_data = d; {rx_par_err, rx_frm_err, rx_brk} = t;
    tick(ctx);
    idle();
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state: only bits 5 and 6 set
    chk(lsr == 8'h60, "R7", "reset value", lsr, 8'h60);
    chk(!irq_rda && !irq_ls && !irq_thre, "R9", "reset irqs", 0, 0);
    rst_n = 1;
    @(negedge clk);

    // single-buffer mode: second byte overruns, fifo_clr ignored (R1, R2)
    ien_rda = 1; ien_ls = 1; ien_thre = 1;
    send(8'h11, 3'b000, "R2 single first");
    send(8'h22, 3'b100, "R2 single overrun");
    fifo_clr = 1; tick("R1 clear ignored single"); idle();
    chk(rd_data == 8'h11, "R1", "clear ignored data", rd_data, 8'h11);
    chk(lsr[7] == 0, "R6", "single no summary", lsr[7], 0);
    lsr_rd = 1; tick("R5 read clears"); idle();
    rd_ready = 1; tick("R1 read byte"); idle();

    // mode change flushes, offered byte dropped (R10)
    send(8'h33, 3'b010, "single tagged");
    fifo_en = 1; rx_valid = 1; rx_data = 8'h44;
    tick("R10 mode change flush"); idle();
    chk(lsr[0] == 0 && lsr[1] == 0, "R10", "flush empty", lsr[1:0], 0);

    // FIFO mode: sweep all tag combinations through the queue
    for (int t = 0; t < 8; t++) begin
      for (int k = 0; k < D + 1; k++) send(8'(t * 16 + k), 3'((t + k) % 8), "R3 fill sweep");
      for (int k = 0; k < D; k++) begin
        lsr_rd = k[0]; rd_ready = 1; tick("R3 drain sweep"); idle();
      end
      lsr_rd = 1; tick("R5 final read"); idle();
    end

    // break stores zero (R4)
    send(8'hA5, 3'b001, "R4 break byte");
    chk(rd_data == 8'h00, "R4", "break data zero", rd_data, 0);
    // status read colliding with an overrun event (R5)
    for (int k = 0; k < D; k++) send(8'(k), 3'b000, "R2 refill");
    lsr_rd = 1; rx_valid = 1; rx_data = 8'h77; tick("R5 read vs overrun"); idle();
    chk(lsr[1] == 1, "R5", "new error wins", lsr[1], 1);
    // read and arrival together at full: accepted (R2)
    rd_ready = 1; rx_valid = 1; rx_data = 8'h99; tick("R2 full pop push"); idle();
    fifo_clr = 1; tick("R1 fifo clear"); idle();

    // transmit status (R7, R8)
    thr_wr = 1; tx_hold_empty = 0; tick("R7 write clears"); idle();
    tx_shift_empty = 0; tick("R8 shift busy");
    tx_hold_empty = 1; tick("R7 hold rise");
    tx_shift_empty = 1; tick("R8 both empty");
    tx_hold_empty = 0; tick("R7 hold fall");
    tx_hold_empty = 1; thr_wr = 1; tick("R7 write beats rise"); idle();

    // pseudo-random sweep over every input
    for (int n = 0; n < 4000; n++) begin
      rng = nxt(rng);
      rx_valid   = rng[2:0] < 3;
      rx_data    = rng[15:8];
      rx_par_err = rng[17:16] == 0;
      rx_frm_err = rng[19:18] == 0;
      rx_brk     = rng[21:20] == 0;
      rd_ready   = rng[24:22] < 2;
      lsr_rd     = rng[26:25] == 0;
      thr_wr     = rng[28:27] == 0;
      fifo_clr   = rng[31:29] == 0 && rng[3];
      if (rng[7:4] == 0 && rng[16]) fifo_en = ~fifo_en;
      rng = nxt(rng);
      tx_hold_empty  = rng[1:0] != 0 ? tx_hold_empty : ~tx_hold_empty;
      tx_shift_empty = rng[2];
      ien_rda = rng[3]; ien_ls = rng[4]; ien_thre = rng[5];
      tick("R3 R6 R9 R10 random");
    end
    idle();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule